// File: doc/BRIEF.md
# Cache Tag Array Maintenance Unit

This block holds the tag store of a four-way set-associative cache that is indexed with the virtual address and tagged with the physical address. A requester hands it one maintenance command at a time. The command is a five-bit code plus three values: an effective (virtual) address, a physical address used for hit comparison, and a tag value to be written. The unit reads the addressed set and decides what to change. It can also ask an external agent to write a dirty line back before the line loses its valid state. The data array, the bus side of writebacks and address translation live elsewhere.

The command code has two fields. Bits [4:2] name the operation and bits [1:0] name the target cache: 0 is instruction, 1 is data, and 2 or 3 is secondary. An instance is built for exactly one target through the `CACHE_SEL` parameter. Index-type commands pick a line straight from address bits. Hit-type commands act only on a valid way whose page matches. Allocating commands choose a victim in least-recently-filled order and never take a locked way.

Top module: `ctm_unit`

## Requirements
- R1: After reset, `busy`, `done`, `hit`, `no_alloc` and `wb_req` are low and `tag_rd` is zero. Every line reads back as the all-zero word, so no line is valid.
- R2: A command is taken when `op_valid` is high and `busy` is low. If no writeback is needed, `busy` stays high for exactly one cycle, and a single-cycle `done` follows with `busy` low.
- R3: The command code splits as operation = `op_code[4:2]` and target = `op_code[1:0]` (0 instruction, 1 data, 2/3 secondary). A command whose target differs from `CACHE_SEL` still gives `done` but changes no line and raises neither `hit` nor `wb_req`.
- R4: Tag word layout: bits [31:12] hold the physical page. Bits [11:OFF_W+IDX_W] hold the line-address bits above the set index and below the page, which is [11:8] at default sizes. Bit 7 is dirty, bit 6 is valid and bit 5 is lock. All other bits read as zero.
- R5: Operation 2 (index store tag) writes `tag_wr`, masked to the R4 fields, into the line chosen by the set index `op_va[OFF_W+IDX_W-1:OFF_W]` and the way `op_va[OFF_W+IDX_W+1:OFF_W+IDX_W]`. Operation 1 (index load tag) copies that line's word to `tag_rd`.
- R6: Operation 0 (index invalidate) clears valid and dirty of the index-selected line and keeps page and lock. In a data instance a valid dirty line is first written back. In an instruction instance no writeback is ever raised.
- R7: Operations 3–6 look for a way whose valid bit is set and whose bits [31:12] equal `op_pa[31:12]`. `hit` rises together with `done` when such a way exists. Operations 4–6 that miss change nothing.
- R8: Operation 4 (hit invalidate) clears valid and dirty of the hit way and never raises a writeback, even when the line is dirty.
- R9: In a data instance, operation 5 (hit writeback-invalidate) clears valid and dirty, and writes back first if the line was dirty. Operation 6 (hit writeback) writes back a dirty hit line and then clears only its dirty bit. A clean hit line is left unchanged.
- R10: A writeback raises `wb_req` with `wb_addr` = {word[31:OFF_W+IDX_W], set index, zero offset}. `wb_req`, `wb_addr` and `busy` hold until `wb_ack` is sampled high. The line changes at that edge, and `done` follows in the next cycle.
- R11: Operation 3 (create dirty exclusive) in a data instance and operation 5 (fill) in an instruction instance allocate on a miss. The victim way receives `op_pa[31:OFF_W+IDX_W]`, valid, and dirty only for create, with lock cleared. A valid dirty data victim is written back first. On a hit, create sets the dirty bit and fill changes nothing.
- R12: Each set keeps its own least-recently-filled order. Starting from way 0 after reset, the victim is the next way in rotating order after the last filled way, skipping any way whose lock bit is set.
- R13: If all four ways of the set are locked, an allocating miss changes nothing, raises no writeback and gives `no_alloc` high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Command present |
| op_code | input | 5 | Operation [4:2], target [1:0] |
| op_va | input | 32 | Effective address (set index, way for index commands) |
| op_pa | input | 32 | Physical address for hit compare and allocation |
| tag_wr | input | 32 | Tag value for index store tag |
| tag_rd | output | 32 | Tag word returned by index load tag |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| hit | output | 1 | Hit-type command found a matching way (with done) |
| no_alloc | output | 1 | Allocation refused, all ways locked (with done) |
| wb_req | output | 1 | Writeback request |
| wb_addr | output | 32 | Line address to write back |
| wb_ack | input | 1 | Writeback accepted |

## Verification
The bench builds two instances with 16 sets, four ways and 16-byte lines: one data instance (`CACHE_SEL` = 1) and one instruction instance (`CACHE_SEL` = 0). With these sizes the index sits in `op_va[7:4]`, the way in `op_va[9:8]`, and the stored extra address bits in [11:8]. A handful of commands can therefore wrap a set's fill order, lock selected ways and force writebacks whose addresses show every field. The data instance reaches the dirty and writeback paths. The instruction instance reaches fill and invalidate without writeback.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  localparam int WORD_W   = 32;
  localparam int PAGE_LSB = 12;
  localparam int BIT_DIRTY = 7;
  localparam int BIT_VALID = 6;
  localparam int BIT_LOCK  = 5;

  typedef enum logic [2:0] {
    OP_IDX_INV  = 3'd0,
    OP_IDX_LD   = 3'd1,
    OP_IDX_ST   = 3'd2,
    OP_MK_DIRTY = 3'd3,
    OP_HIT_INV  = 3'd4,
    OP_HIT_WBI  = 3'd5,
    OP_HIT_WB   = 3'd6,
    OP_NONE     = 3'd7
  } ctm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_WB   = 2'd2
  } ctm_st_e;

  localparam logic [1:0] TGT_INSTR = 2'd0;
  localparam logic [1:0] TGT_DATA  = 2'd1;
endpackage

// File: rtl/ctm_tag_store.sv
module ctm_tag_store #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [IDX_W-1:0]           rd_set,
  output logic [WAYS-1:0][31:0]      rd_words,
  input  logic                       we,
  input  logic [IDX_W-1:0]           wr_set,
  input  logic [WAY_W-1:0]           wr_way,
  input  logic [31:0]                wr_word
);
  logic [SETS-1:0][WAYS-1:0][31:0] mem_q;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic line_en;
      assign line_en = we && (wr_set == IDX_W'(s)) && (wr_way == WAY_W'(w));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_q[s][w] <= '0;
        end else if (line_en) begin
          mem_q[s][w] <= wr_word;
        end
      end
    end
  end

  assign rd_words = mem_q[rd_set];
endmodule

// File: rtl/ctm_hit_cmp.sv
module ctm_hit_cmp #(
  parameter int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][31:0] words,
  input  logic [19:0]           pa_page,
  output logic [WAYS-1:0]       hit_vec,
  output logic                  hit_any,
  output logic [WAY_W-1:0]      hit_way
);
  import ctm_pkg::*;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = words[w][BIT_VALID] && (words[w][31:PAGE_LSB] == pa_page);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/ctm_lrf.sv
module ctm_lrf #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] set_sel,
  input  logic [WAYS-1:0]  lock_vec,
  output logic [WAY_W-1:0] victim,
  output logic             all_locked,
  input  logic             adv,
  input  logic [WAY_W-1:0] adv_way
);
  logic [SETS-1:0][WAY_W-1:0] ptr_q;
  logic [WAY_W-1:0]           cur;
  logic [WAY_W-1:0]           cand;

  for (genvar s = 0; s < SETS; s++) begin : g_ptr
    logic ptr_en;
    assign ptr_en = adv && (set_sel == IDX_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[s] <= '0;
      end else if (ptr_en) begin
        ptr_q[s] <= adv_way + WAY_W'(1);
      end
    end
  end

  always_comb begin
    cur        = ptr_q[set_sel];
    victim     = cur;
    all_locked = 1'b1;
    cand       = cur;
    for (int k = WAYS - 1; k >= 0; k--) begin
      cand = cur + WAY_W'(k);
      if (!lock_vec[cand]) begin
        victim     = cand;
        all_locked = 1'b0;
      end
    end
  end
endmodule

// File: rtl/ctm_unit.sv
module ctm_unit #(
  parameter int         SETS       = 16,
  parameter int         WAYS       = 4,
  parameter int         LINE_BYTES = 16,
  parameter logic [1:0] CACHE_SEL  = 2'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [4:0]  op_code,
  input  logic [31:0] op_va,
  input  logic [31:0] op_pa,
  input  logic [31:0] tag_wr,
  output logic [31:0] tag_rd,
  output logic        busy,
  output logic        done,
  output logic        hit,
  output logic        no_alloc,
  output logic        wb_req,
  output logic [31:0] wb_addr,
  input  logic        wb_ack
);
  import ctm_pkg::*;

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int HI_LO = OFF_W + IDX_W;
  localparam logic [31:0] KEEP_MASK = 32'hFFFF_F000
                                    | ((32'h1 << PAGE_LSB) - (32'h1 << HI_LO))
                                    | (32'h1 << BIT_DIRTY) | (32'h1 << BIT_VALID)
                                    | (32'h1 << BIT_LOCK);
  localparam bit IS_DATA = (CACHE_SEL == TGT_DATA);

  // captured command
  ctm_st_e              state_q, state_n;
  logic [4:0]           code_q;
  logic [IDX_W-1:0]     set_q;
  logic [WAY_W-1:0]     way_q;
  logic [31:HI_LO]      pa_q;
  logic [31:0]          tlo_q;

  // pending update while a writeback is outstanding
  logic [WAY_W-1:0]     pend_way_q;
  logic [31:0]          pend_word_q;
  logic                 pend_adv_q;
  logic                 pend_hit_q;

  // output registers
  logic [31:0]          tag_rd_q;
  logic                 done_q, hit_q, noalloc_q, wb_req_q;
  logic [31:0]          wb_addr_q;

  // array views
  logic [WAYS-1:0][31:0] rd_words;
  logic [WAYS-1:0]       hit_vec;
  logic                  hit_any;
  logic [WAY_W-1:0]      hit_way;
  logic [WAYS-1:0]       lock_vec;
  logic [WAY_W-1:0]      victim;
  logic                  all_locked;

  // next-state decisions
  ctm_op_e              op_s;
  logic                 tgt_match;
  logic                 accept;
  logic [31:0]          line_w, hit_w, vic_w, alloc_w;
  logic                 do_write, need_wb, adv_n, hit_n, noalloc_n, ld_tag;
  logic [WAY_W-1:0]     upd_way;
  logic [31:0]          upd_word, wb_src, wb_addr_n;
  logic                 commit_exec, commit_wb;
  logic                 ts_we;
  logic [WAY_W-1:0]     ts_way;
  logic [31:0]          ts_word;
  logic                 lrf_adv;
  logic [WAY_W-1:0]     lrf_way;

  ctm_tag_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_set  (set_q),
    .rd_words(rd_words),
    .we      (ts_we),
    .wr_set  (set_q),
    .wr_way  (ts_way),
    .wr_word (ts_word)
  );

  ctm_hit_cmp #(.WAYS(WAYS)) u_cmp (
    .words  (rd_words),
    .pa_page(pa_q[31:PAGE_LSB]),
    .hit_vec(hit_vec),
    .hit_any(hit_any),
    .hit_way(hit_way)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_lock
    assign lock_vec[w] = rd_words[w][BIT_LOCK];
  end

  ctm_lrf #(.SETS(SETS), .WAYS(WAYS)) u_lrf (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_sel   (set_q),
    .lock_vec  (lock_vec),
    .victim    (victim),
    .all_locked(all_locked),
    .adv       (lrf_adv),
    .adv_way   (lrf_way)
  );

  assign op_s      = ctm_op_e'(code_q[4:2]);
  assign tgt_match = (code_q[1:0] == CACHE_SEL);
  assign accept    = op_valid && (state_q == ST_IDLE);
  assign line_w    = rd_words[way_q];
  assign hit_w     = rd_words[hit_way];
  assign vic_w     = rd_words[victim];

  // word written on allocation, dirty bit added by the caller
  always_comb begin
    alloc_w            = '0;
    alloc_w[31:HI_LO]  = pa_q;
    alloc_w[BIT_VALID] = 1'b1;
  end

  // command decode and next state
  always_comb begin
    state_n   = state_q;
    do_write  = 1'b0;
    need_wb   = 1'b0;
    adv_n     = 1'b0;
    hit_n     = 1'b0;
    noalloc_n = 1'b0;
    ld_tag    = 1'b0;
    upd_way   = way_q;
    upd_word  = line_w;
    wb_src    = line_w;
    unique case (state_q)
      ST_IDLE: if (accept) state_n = ST_EXEC;
      ST_EXEC: begin
        if (tgt_match) begin
          hit_n = hit_any && (code_q[4:2] >= 3'd3) && (op_s != OP_NONE);
          unique case (op_s)
            OP_IDX_INV: begin
              upd_word            = line_w;
              upd_word[BIT_VALID] = 1'b0;
              upd_word[BIT_DIRTY] = 1'b0;
              do_write            = 1'b1;
              need_wb             = IS_DATA && line_w[BIT_VALID] && line_w[BIT_DIRTY];
            end
            OP_IDX_LD: ld_tag = 1'b1;
            OP_IDX_ST: begin
              upd_word = tlo_q & KEEP_MASK;
              do_write = 1'b1;
            end
            OP_MK_DIRTY: begin
              if (IS_DATA) begin
                if (hit_any) begin
                  upd_way             = hit_way;
                  upd_word            = hit_w;
                  upd_word[BIT_DIRTY] = 1'b1;
                  do_write            = 1'b1;
                end else if (all_locked) begin
                  noalloc_n = 1'b1;
                end else begin
                  upd_way             = victim;
                  upd_word            = alloc_w;
                  upd_word[BIT_DIRTY] = 1'b1;
                  do_write            = 1'b1;
                  adv_n               = 1'b1;
                  wb_src              = vic_w;
                  need_wb             = vic_w[BIT_VALID] && vic_w[BIT_DIRTY];
                end
              end
            end
            OP_HIT_INV: begin
              if (hit_any) begin
                upd_way             = hit_way;
                upd_word            = hit_w;
                upd_word[BIT_VALID] = 1'b0;
                upd_word[BIT_DIRTY] = 1'b0;
                do_write            = 1'b1;
              end
            end
            OP_HIT_WBI: begin
              if (IS_DATA) begin
                if (hit_any) begin
                  upd_way             = hit_way;
                  upd_word            = hit_w;
                  upd_word[BIT_VALID] = 1'b0;
                  upd_word[BIT_DIRTY] = 1'b0;
                  do_write            = 1'b1;
                  wb_src              = hit_w;
                  need_wb             = hit_w[BIT_DIRTY];
                end
              end else begin
                if (!hit_any) begin
                  if (all_locked) begin
                    noalloc_n = 1'b1;
                  end else begin
                    upd_way  = victim;
                    upd_word = alloc_w;
                    do_write = 1'b1;
                    adv_n    = 1'b1;
                  end
                end
              end
            end
            OP_HIT_WB: begin
              if (IS_DATA && hit_any && hit_w[BIT_DIRTY]) begin
                upd_way             = hit_way;
                upd_word            = hit_w;
                upd_word[BIT_DIRTY] = 1'b0;
                do_write            = 1'b1;
                wb_src              = hit_w;
                need_wb             = 1'b1;
              end
            end
            default: ;
          endcase
        end
        state_n = need_wb ? ST_WB : ST_IDLE;
      end
      ST_WB: if (wb_ack) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_comb begin
    wb_addr_n                  = '0;
    wb_addr_n[31:HI_LO]        = wb_src[31:HI_LO];
    wb_addr_n[HI_LO-1:OFF_W]   = set_q;
  end

  assign commit_exec = (state_q == ST_EXEC) && !need_wb;
  assign commit_wb   = (state_q == ST_WB) && wb_ack;
  assign ts_we       = (commit_exec && do_write) || commit_wb;
  assign ts_way      = commit_wb ? pend_way_q  : upd_way;
  assign ts_word     = commit_wb ? pend_word_q : upd_word;
  assign lrf_adv     = (commit_exec && adv_n) || (commit_wb && pend_adv_q);
  assign lrf_way     = commit_wb ? pend_way_q : upd_way;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      code_q      <= '0;
      set_q       <= '0;
      way_q       <= '0;
      pa_q        <= '0;
      tlo_q       <= '0;
      pend_way_q  <= '0;
      pend_word_q <= '0;
      pend_adv_q  <= 1'b0;
      pend_hit_q  <= 1'b0;
      tag_rd_q    <= '0;
      done_q      <= 1'b0;
      hit_q       <= 1'b0;
      noalloc_q   <= 1'b0;
      wb_req_q    <= 1'b0;
      wb_addr_q   <= '0;
    end else begin
      state_q <= state_n;
      if (accept) begin
        code_q <= op_code;
        set_q  <= op_va[HI_LO-1:OFF_W];
        way_q  <= op_va[HI_LO+WAY_W-1:HI_LO];
        pa_q   <= op_pa[31:HI_LO];
        tlo_q  <= tag_wr;
      end
      if ((state_q == ST_EXEC) && need_wb) begin
        pend_way_q  <= upd_way;
        pend_word_q <= upd_word;
        pend_adv_q  <= adv_n;
        pend_hit_q  <= hit_n;
        wb_addr_q   <= wb_addr_n;
      end
      if ((state_q == ST_EXEC) && ld_tag) begin
        tag_rd_q <= line_w;
      end
      wb_req_q  <= ((state_q == ST_EXEC) && need_wb) || ((state_q == ST_WB) && !wb_ack);
      done_q    <= commit_exec || commit_wb;
      hit_q     <= (commit_exec && hit_n) || (commit_wb && pend_hit_q);
      noalloc_q <= commit_exec && noalloc_n;
    end
  end

  assign tag_rd   = tag_rd_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign hit      = hit_q;
  assign no_alloc = noalloc_q;
  assign wb_req   = wb_req_q;
  assign wb_addr  = wb_addr_q;
endmodule

// File: rtl/ctm_unit_chk.sv
module ctm_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic        busy,
  input logic        done,
  input logic        hit,
  input logic        no_alloc,
  input logic        wb_req,
  input logic [31:0] wb_addr,
  input logic        wb_ack
);
  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy) |=> busy);
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr)));
  a_r10_wb_release: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && wb_ack) |=> (done && !wb_req));
  a_r10_wb_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> busy);
  a_r13_noalloc: assert property (@(posedge clk) disable iff (!rst_n)
    no_alloc |-> (done && !hit && !wb_req));
  a_r7_hit_done: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> done);
endmodule

bind ctm_unit ctm_unit_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .op_valid(op_valid),
  .busy    (busy),
  .done    (done),
  .hit     (hit),
  .no_alloc(no_alloc),
  .wb_req  (wb_req),
  .wb_addr (wb_addr),
  .wb_ack  (wb_ack)
);

// File: tb/ctm_unit_test.sv
`timescale 1ns/1ps
module ctm_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // data instance
  logic        d_valid = 0, d_ack = 0;
  logic [4:0]  d_code = 0;
  logic [31:0] d_va = 0, d_pa = 0, d_tw = 0;
  logic [31:0] d_tag_rd, d_wb_addr;
  logic        d_busy, d_done, d_hit, d_noalloc, d_wb_req;
  // instruction instance
  logic        i_valid = 0, i_ack = 0;
  logic [4:0]  i_code = 0;
  logic [31:0] i_va = 0, i_pa = 0, i_tw = 0;
  logic [31:0] i_tag_rd, i_wb_addr;
  logic        i_busy, i_done, i_hit, i_noalloc, i_wb_req;

  ctm_unit #(.SETS(16), .WAYS(4), .LINE_BYTES(16), .CACHE_SEL(2'd1)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(d_valid), .op_code(d_code), .op_va(d_va),
    .op_pa(d_pa), .tag_wr(d_tw), .tag_rd(d_tag_rd), .busy(d_busy), .done(d_done),
    .hit(d_hit), .no_alloc(d_noalloc), .wb_req(d_wb_req), .wb_addr(d_wb_addr), .wb_ack(d_ack));

  ctm_unit #(.SETS(16), .WAYS(4), .LINE_BYTES(16), .CACHE_SEL(2'd0)) uut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(i_valid), .op_code(i_code), .op_va(i_va),
    .op_pa(i_pa), .tag_wr(i_tw), .tag_rd(i_tag_rd), .busy(i_busy), .done(i_done),
    .hit(i_hit), .no_alloc(i_noalloc), .wb_req(i_wb_req), .wb_addr(i_wb_addr), .wb_ack(i_ack));

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // results of the last command
  logic        r_busy1, r_done, r_busy_after, r_wb, r_hit, r_noalloc, r_hold_bad;
  logic [31:0] r_wbaddr, r_tag;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] va_of(input int s, input int w);
    return 32'h8000_0000 | (32'(w) << 8) | (32'(s) << 4);
  endfunction

  function automatic logic [31:0] pa_of(input logic [19:0] pg, input int s);
    return {pg, 4'h3, 4'(s), 4'h0};
  endfunction

  task automatic do_op(input bit use_i, input logic [4:0] code, input logic [31:0] va,
                       input logic [31:0] pa, input logic [31:0] tw, input int ack_dly);
    @(negedge clk);
    if (use_i) begin i_valid = 1; i_code = code; i_va = va; i_pa = pa; i_tw = tw; end
    else       begin d_valid = 1; d_code = code; d_va = va; d_pa = pa; d_tw = tw; end
    @(negedge clk);
    i_valid = 0; d_valid = 0;
    r_busy1 = use_i ? i_busy : d_busy;
    @(negedge clk);
    r_wb = 0; r_hold_bad = 0; r_wbaddr = '0;
    if (!(use_i ? i_done : d_done) && (use_i ? i_wb_req : d_wb_req)) begin
      r_wb = 1;
      r_wbaddr = use_i ? i_wb_addr : d_wb_addr;
      for (int k = 0; k < ack_dly; k++) begin
        @(negedge clk);
        if (!(use_i ? i_wb_req : d_wb_req) || !(use_i ? i_busy : d_busy) ||
            ((use_i ? i_wb_addr : d_wb_addr) !== r_wbaddr)) r_hold_bad = 1;
      end
      if (use_i) i_ack = 1; else d_ack = 1;
      @(negedge clk);
      i_ack = 0; d_ack = 0;
    end
    r_done       = use_i ? i_done : d_done;
    r_busy_after = use_i ? i_busy : d_busy;
    r_hit        = use_i ? i_hit : d_hit;
    r_noalloc    = use_i ? i_noalloc : d_noalloc;
    r_tag        = use_i ? i_tag_rd : d_tag_rd;
  endtask

  task automatic load_tag(input bit use_i, input int s, input int w);
    do_op(use_i, use_i ? 5'h04 : 5'h05, va_of(s, w), 32'h0, 32'h0, 0);
  endtask

  task automatic t_reset;
    check("R1 busy", {31'b0, d_busy}, 0);
    check("R1 done", {31'b0, d_done}, 0);
    check("R1 wb_req", {31'b0, d_wb_req}, 0);
    check("R1 hit/no_alloc", {30'b0, d_hit, d_noalloc}, 0);
    check("R1 tag_rd", d_tag_rd, 0);
    load_tag(0, 11, 3);
    check("R1 line cleared", r_tag, 0);
  endtask

  task automatic t_store_load;
    do_op(0, 5'h09, va_of(3, 2), 0, 32'hABCD_E5FF, 0);
    check("R2 busy one cycle", {31'b0, r_busy1}, 1);
    check("R2 done strobe", {30'b0, r_done, r_busy_after}, 32'h2);
    check("R2 no writeback", {31'b0, r_wb}, 0);
    load_tag(0, 3, 2);
    check("R5 R4 store/load masked", r_tag, 32'hABCD_E5E0);
    load_tag(0, 3, 1);
    check("R5 neighbour way untouched", r_tag, 0);
  endtask

  task automatic t_alloc_order;
    logic [19:0] pg [5] = '{20'h11111, 20'h22222, 20'h33333, 20'h44444, 20'h55555};
    for (int i = 0; i < 4; i++) begin
      do_op(0, 5'h0D, va_of(5, 0), pa_of(pg[i], 5), 0, 0);
      check("R11 miss no hit/wb", {30'b0, r_hit, r_wb}, 0);
    end
    for (int i = 0; i < 4; i++) begin
      load_tag(0, 5, i);
      check("R12 R11 fill order", r_tag, {pg[i], 12'h3C0});
    end
    do_op(0, 5'h0D, va_of(5, 0), pa_of(pg[0], 5), 0, 0);
    check("R11 create on hit", {30'b0, r_hit, r_wb}, 32'h2);
    do_op(0, 5'h0D, va_of(5, 0), pa_of(pg[4], 5), 0, 3);
    check("R11 dirty victim written back", {31'b0, r_wb}, 1);
    check("R10 wb address", r_wbaddr, 32'h1111_1350);
    check("R10 held until ack", {31'b0, r_hold_bad}, 0);
    check("R10 done after ack", {30'b0, r_done, r_busy_after}, 32'h2);
    load_tag(0, 5, 0);
    check("R12 least recently filled replaced", r_tag, 32'h5555_53C0);
  endtask

  task automatic t_hit_ops;
    do_op(0, 5'h19, va_of(5, 0), pa_of(20'h22222, 5), 0, 1);
    check("R9 hit wb dirty", {30'b0, r_hit, r_wb}, 32'h3);
    check("R10 hit wb address", r_wbaddr, 32'h2222_2350);
    load_tag(0, 5, 1);
    check("R9 dirty cleared valid kept", r_tag, 32'h2222_2340);
    do_op(0, 5'h19, va_of(5, 0), pa_of(20'h22222, 5), 0, 0);
    check("R9 hit wb clean no wb", {30'b0, r_hit, r_wb}, 32'h2);
    do_op(0, 5'h15, va_of(5, 0), pa_of(20'h22222, 5), 0, 0);
    check("R9 wbinv clean no wb", {30'b0, r_hit, r_wb}, 32'h2);
    load_tag(0, 5, 1);
    check("R9 wbinv cleared", r_tag, 32'h2222_2300);
    do_op(0, 5'h11, va_of(5, 0), pa_of(20'h33333, 5), 0, 0);
    check("R8 hit inv dirty no wb", {30'b0, r_hit, r_wb}, 32'h2);
    load_tag(0, 5, 2);
    check("R8 invalidated", r_tag, 32'h3333_3300);
    do_op(0, 5'h15, va_of(5, 0), pa_of(20'h44444, 5), 0, 0);
    check("R9 wbinv dirty wb", {30'b0, r_hit, r_wb}, 32'h3);
    check("R9 wbinv address", r_wbaddr, 32'h4444_4350);
    load_tag(0, 5, 3);
    check("R9 wbinv cleared dirty line", r_tag, 32'h4444_4300);
    do_op(0, 5'h11, va_of(5, 0), pa_of(20'h99999, 5), 0, 0);
    check("R7 miss no hit", {30'b0, r_hit, r_wb}, 0);
    load_tag(0, 5, 0);
    check("R7 miss changes nothing", r_tag, 32'h5555_53C0);
  endtask

  task automatic t_index_inv;
    do_op(0, 5'h01, va_of(5, 0), 0, 0, 0);
    check("R6 index wbinv dirty", {31'b0, r_wb}, 1);
    check("R6 index wb address", r_wbaddr, 32'h5555_5350);
    load_tag(0, 5, 0);
    check("R6 page kept valid cleared", r_tag, 32'h5555_5300);
    do_op(0, 5'h01, va_of(5, 0), 0, 0, 0);
    check("R6 clean line no wb", {31'b0, r_wb}, 0);
  endtask

  task automatic t_lock;
    do_op(0, 5'h09, va_of(7, 1), 0, 32'h0000_0020, 0);
    do_op(0, 5'h0D, va_of(7, 0), pa_of(20'hA0000, 7), 0, 0);
    do_op(0, 5'h0D, va_of(7, 0), pa_of(20'hB0000, 7), 0, 0);
    do_op(0, 5'h0D, va_of(7, 0), pa_of(20'hC0000, 7), 0, 0);
    load_tag(0, 7, 2);
    check("R12 locked way skipped", r_tag, 32'hB000_03C0);
    do_op(0, 5'h0D, va_of(7, 0), pa_of(20'hD0000, 7), 0, 0);
    check("R12 wrap victim way0", r_wbaddr, 32'hA000_0370);
    load_tag(0, 7, 1);
    check("R12 R4 locked way untouched", r_tag, 32'h0000_0020);
    load_tag(0, 7, 0);
    check("R12 way0 refilled", r_tag, 32'hD000_03C0);
  endtask

  task automatic t_all_locked;
    for (int w = 0; w < 4; w++) do_op(0, 5'h09, va_of(9, w), 0, 32'h0000_0020, 0);
    do_op(0, 5'h0D, va_of(9, 0), pa_of(20'h77777, 9), 0, 0);
    check("R13 no_alloc with done", {29'b0, r_noalloc, r_done, r_wb}, 32'h6);
    for (int w = 0; w < 4; w++) begin
      load_tag(0, 9, w);
      check("R13 set unchanged", r_tag, 32'h0000_0020);
    end
  endtask

  task automatic t_target;
    do_op(0, 5'h10, va_of(7, 0), pa_of(20'hB0000, 7), 0, 0);
    check("R3 other target ignored", {29'b0, r_done, r_hit, r_wb}, 32'h4);
    do_op(0, 5'h12, va_of(7, 0), pa_of(20'hB0000, 7), 0, 0);
    check("R3 secondary target ignored", {29'b0, r_done, r_hit, r_wb}, 32'h4);
    load_tag(0, 7, 2);
    check("R3 line kept", r_tag, 32'hB000_03C0);
  endtask

  task automatic t_instr;
    do_op(1, 5'h14, va_of(2, 0), pa_of(20'h12121, 2), 0, 0);
    check("R11 fill miss", {30'b0, r_hit, r_wb}, 0);
    load_tag(1, 2, 0);
    check("R11 fill valid clean", r_tag, 32'h1212_1340);
    do_op(1, 5'h14, va_of(2, 0), pa_of(20'h12121, 2), 0, 0);
    check("R11 fill hit", {30'b0, r_hit, r_wb}, 32'h2);
    load_tag(1, 2, 1);
    check("R11 fill hit no allocation", r_tag, 0);
    do_op(1, 5'h00, va_of(2, 0), 0, 0, 0);
    check("R6 instr invalidate no wb", {30'b0, r_done, r_wb}, 32'h2);
    load_tag(1, 2, 0);
    check("R6 instr line invalid", r_tag, 32'h1212_1300);
    do_op(1, 5'h0D, va_of(2, 0), pa_of(20'h34343, 2), 0, 0);
    load_tag(1, 2, 1);
    check("R3 data op on instr unit ignored", r_tag, 0);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_store_load();
    t_alloc_order();
    t_hit_ops();
    t_index_inv();
    t_lock();
    t_all_locked();
    t_target();
    t_instr();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule